// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block is the floating-point register file of a scalar core. It holds 32 architectural registers whose physical width is a parameter: 64 bits when double precision is built in, 32 bits when it is not. Half, single and double precision values all share these registers. Whenever a value narrower than the register is written, the bits above it are filled with ones. This marks the register as holding a boxed narrow value.

Each of the two read ports names a register, a format and a raw-transfer flag. On a normal read of a narrow format, the port first checks that every bit above the format's width is one. If any of them is not, the port returns the canonical quiet NaN of the requested format instead of the low bits. Moves to the integer file and stores to memory copy bits without interpreting them. For those, the caller sets the raw flag, and the low bits come back as they are. Every result is zero-extended onto a 64-bit bus.

Top module: `fpbox_regfile`

## Requirements
- R1: A write in a format narrower than the register width stores the value in the low bits and sets every bit above it to one.
- R2: A write whose format width equals the register width stores the 64-bit value unchanged, and a read in that format returns it exactly.
- R3: A normal (non-raw) read in a narrower format whose upper bits are not all ones returns the canonical quiet NaN: 16'h7E00 for half, 32'h7FC00000 for single.
- R4: A normal read in a narrower format whose upper bits are all ones returns the low bits of the register unchanged.
- R5: With the raw flag set (1), a narrower read returns the low bits unchanged whatever the upper bits hold.
- R6: Format code 00 is single (32 bits), 01 is double (64 bits), 10 is half (16 bits). Code 11 is reserved: a write with it is ignored, and a read with it returns zero.
- R7: When the register width is 32, double format is illegal: such a write is ignored and such a read returns zero, while half values are boxed inside 32 bits.
- R8: Writes take effect on the rising clock edge. Reads are combinational, so a read of the register being written in the same cycle returns the old contents.
- R9: Read results narrower than 64 bits are zero-extended on the 64-bit output bus.
- R10: An active-high synchronous reset clears all registers to zero. A normal narrow read of a cleared register then returns the canonical NaN, and a raw read returns zero.
- R11: The two read ports operate independently, each with its own address, format and raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_fmt | input | 2 | Write format code |
| wr_data | input | 64 | Write value, low bits used for narrow formats |
| rd_addr_a | input | 5 | Port A register index |
| rd_fmt_a | input | 2 | Port A format code |
| rd_raw_a | input | 1 | Port A raw transfer, skips the box check |
| rd_data_a | output | 64 | Port A result, zero-extended |
| rd_addr_b | input | 5 | Port B register index |
| rd_fmt_b | input | 2 | Port B format code |
| rd_raw_b | input | 1 | Port B raw transfer, skips the box check |
| rd_data_b | output | 64 | Port B result, zero-extended |

## Verification
Some properties are checked on every cycle. Zero-extension of half and single results holds at all times, and so does the zero result for the reserved code and for illegal double access. A half or double write read back on the next cycle must return the written bits, and a narrow read straight after reset must return the canonical NaN. Other behaviour depends on what a register held earlier, so only the bench scenarios can show it. This covers cross-format reads against a mismatched box, the raw-flag bypass on an unboxed register, the old value seen on a same-cycle read, and a second instance built with 32-bit registers.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

    localparam int BUS_W = 64;
    localparam int HALF_W = 16;
    localparam int SNGL_W = 32;

    typedef enum logic [1:0] {
        FMT_S = 2'b00,
        FMT_D = 2'b01,
        FMT_H = 2'b10,
        FMT_X = 2'b11
    } fmt_e;

    localparam logic [HALF_W-1:0] QNAN_H = 16'h7E00;
    localparam logic [SNGL_W-1:0] QNAN_S = 32'h7FC0_0000;
    localparam logic [BUS_W-1:0]  QNAN_D = 64'h7FF8_0000_0000_0000;

    // Box a value into a full 64-bit word, ones above the format width.
    function automatic logic [BUS_W-1:0] box_to_bus(fmt_e f, logic [BUS_W-1:0] v);
        logic [BUS_W-1:0] r;
        case (f)
            FMT_H:   r = {{(BUS_W-HALF_W){1'b1}}, v[HALF_W-1:0]};
            FMT_S:   r = {{(BUS_W-SNGL_W){1'b1}}, v[SNGL_W-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

    // Whether a format may be used with registers of width flen.
    function automatic logic fmt_legal(fmt_e f, int flen);
        return (f == FMT_H) || (f == FMT_S) || ((f == FMT_D) && (flen >= BUS_W));
    endfunction

endpackage

// File: rtl/fpbox_pack.sv
module fpbox_pack
    import fpbox_pkg::*;
#(
    parameter int FLEN = 64
) (
    input  logic [1:0]       fmt,
    input  logic [BUS_W-1:0] val,
    output logic [FLEN-1:0]  word,
    output logic             ok
);
    fmt_e             f;
    logic [BUS_W-1:0] wide;

    always_comb begin
        f    = fmt_e'(fmt);
        wide = box_to_bus(f, val);
        word = wide[FLEN-1:0];
        ok   = fmt_legal(f, FLEN);
    end
endmodule

// File: rtl/fpbox_unpack.sv
module fpbox_unpack
    import fpbox_pkg::*;
#(
    parameter int FLEN = 64
) (
    input  logic [FLEN-1:0]  word,
    input  logic [1:0]       fmt,
    input  logic             raw,
    output logic [BUS_W-1:0] res
);
    fmt_e             f;
    logic [BUS_W-1:0] w64;
    logic             h_box;
    logic             s_box;

    always_comb begin
        f = fmt_e'(fmt);
        // Bits absent from a narrow register read as ones, i.e. as boxed.
        w64 = '1;
        w64[FLEN-1:0] = word;
        h_box = &w64[BUS_W-1:HALF_W];
        s_box = &w64[BUS_W-1:SNGL_W];
        res = '0;
        case (f)
            FMT_H: res[HALF_W-1:0] = (raw || h_box) ? w64[HALF_W-1:0] : QNAN_H;
            FMT_S: res[SNGL_W-1:0] = (raw || s_box) ? w64[SNGL_W-1:0] : QNAN_S;
            FMT_D: if (FLEN >= BUS_W) res = w64;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fpbox_store.sv
module fpbox_store #(
    parameter int FLEN = 64,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [FLEN-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][FLEN-1:0] rdata
);
    logic [FLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/fpbox_regfile.sv
module fpbox_regfile
    import fpbox_pkg::*;
#(
    parameter int FLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [1:0]       wr_fmt,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [1:0]       rd_fmt_a,
    input  logic             rd_raw_a,
    output logic [BUS_W-1:0] rd_data_a,
    input  logic [AW-1:0]    rd_addr_b,
    input  logic [1:0]       rd_fmt_b,
    input  logic             rd_raw_b,
    output logic [BUS_W-1:0] rd_data_b
);
    localparam int NRD = 2;

    logic [FLEN-1:0]            boxed;
    logic                       fmt_ok;
    logic [NRD-1:0][AW-1:0]     raddr;
    logic [NRD-1:0][FLEN-1:0]   rword;
    logic [NRD-1:0][1:0]        rfmt;
    logic [NRD-1:0]             rraw;
    logic [NRD-1:0][BUS_W-1:0]  rres;

    fpbox_pack #(.FLEN(FLEN)) u_pack (
        .fmt  (wr_fmt),
        .val  (wr_data),
        .word (boxed),
        .ok   (fmt_ok)
    );

    fpbox_store #(.FLEN(FLEN), .NREG(NREG), .NRD(NRD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && fmt_ok),
        .waddr (wr_addr),
        .wdata (boxed),
        .raddr (raddr),
        .rdata (rword)
    );

    assign raddr = {rd_addr_b, rd_addr_a};
    assign rfmt  = {rd_fmt_b, rd_fmt_a};
    assign rraw  = {rd_raw_b, rd_raw_a};

    for (genvar p = 0; p < NRD; p++) begin : g_port
        fpbox_unpack #(.FLEN(FLEN)) u_unpack (
            .word (rword[p]),
            .fmt  (rfmt[p]),
            .raw  (rraw[p]),
            .res  (rres[p])
        );
    end

    assign rd_data_a = rres[0];
    assign rd_data_b = rres[1];
endmodule

// File: rtl/fpbox_regfile_chk.sv
module fpbox_regfile_chk
    import fpbox_pkg::*;
#(
    parameter int FLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [1:0]       wr_fmt,
    input logic [BUS_W-1:0] wr_data,
    input logic [AW-1:0]    rd_addr_a,
    input logic [1:0]       rd_fmt_a,
    input logic             rd_raw_a,
    input logic [BUS_W-1:0] rd_data_a,
    input logic [AW-1:0]    rd_addr_b,
    input logic [1:0]       rd_fmt_b,
    input logic             rd_raw_b,
    input logic [BUS_W-1:0] rd_data_b
);
    AST_ZEXT_HALF_A: assert property (@(posedge clk) disable iff (rst)
        rd_fmt_a == FMT_H |-> rd_data_a[63:16] == '0); // R9
    AST_ZEXT_SNGL_B: assert property (@(posedge clk) disable iff (rst)
        rd_fmt_b == FMT_S |-> rd_data_b[63:32] == '0); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_fmt_a == FMT_X |-> rd_data_a == '0); // R6
    AST_CLEARED_NAN_A: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && rd_fmt_a == FMT_H && !rd_raw_a |-> rd_data_a == 64'h7E00); // R10
    AST_CLEARED_NAN_B: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && rd_fmt_b == FMT_S && !rd_raw_b |-> rd_data_b == 64'h7FC0_0000); // R10
    AST_HALF_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en && wr_fmt == FMT_H) && rd_addr_a == $past(wr_addr)
        && rd_fmt_a == FMT_H |-> rd_data_a == {48'd0, $past(wr_data[15:0])}); // R1

    if (FLEN >= 64) begin : g_wide
        AST_DOUBLE_KEEP: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(wr_en && wr_fmt == FMT_D) && rd_addr_b == $past(wr_addr)
            && rd_fmt_b == FMT_D |-> rd_data_b == $past(wr_data)); // R2
    end else begin : g_narrow
        AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst)
            rd_fmt_b == FMT_D |-> rd_data_b == '0); // R7
    end
endmodule

bind fpbox_regfile fpbox_regfile_chk #(.FLEN(FLEN), .NREG(NREG)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_fmt(wr_fmt),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_fmt_a(rd_fmt_a),
    .rd_raw_a(rd_raw_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b),
    .rd_fmt_b(rd_fmt_b), .rd_raw_b(rd_raw_b), .rd_data_b(rd_data_b)
);

// File: tb/test_fpbox_regfile.sv
`timescale 1ns/1ps
module test_fpbox_regfile;

    typedef struct packed {
        logic [1:0]  wfmt;
        logic [63:0] wdata;
        logic [1:0]  rfmt;
        logic        raw;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    // Format codes: 00 single, 01 double, 10 half, 11 reserved.
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 64'h4009_21FB_5444_2D18, 2'b01, 1'b0, 64'h4009_21FB_5444_2D18}, // R2
        '{2'b00, 64'h1234_5678_3F80_0000, 2'b00, 1'b0, 64'h0000_0000_3F80_0000}, // R4 R9
        '{2'b00, 64'h0000_0000_3F80_0000, 2'b01, 1'b0, 64'hFFFF_FFFF_3F80_0000}, // R1
        '{2'b10, 64'hABCD_0000_0000_3C00, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_3C00}, // R1
        '{2'b10, 64'h0000_0000_0000_3C00, 2'b00, 1'b0, 64'h0000_0000_FFFF_3C00}, // R4
        '{2'b01, 64'h0000_0000_4049_0FDB, 2'b00, 1'b0, 64'h0000_0000_7FC0_0000}, // R3
        '{2'b01, 64'h0000_0000_4049_0FDB, 2'b00, 1'b1, 64'h0000_0000_4049_0FDB}, // R5
        '{2'b00, 64'h0000_0000_4049_0FDB, 2'b10, 1'b0, 64'h0000_0000_0000_7E00}, // R3
        '{2'b00, 64'h0000_0000_4049_0FDB, 2'b10, 1'b1, 64'h0000_0000_0000_0FDB}, // R5
        '{2'b01, 64'hFFFF_FFFF_FFFF_1234, 2'b10, 1'b0, 64'h0000_0000_0000_1234}, // R4
        '{2'b10, 64'h0000_0000_0000_5555, 2'b10, 1'b0, 64'h0000_0000_0000_5555}, // R1
        '{2'b11, 64'hDEAD_BEEF_DEAD_BEEF, 2'b01, 1'b0, 64'h0000_0000_0000_0000}, // R6
        '{2'b01, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 64'h0000_0000_0000_0000}  // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [1:0]  wr_fmt = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [1:0]  rd_fmt_a = '0;
    logic        rd_raw_a = 1'b0;
    logic [63:0] rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [1:0]  rd_fmt_b = '0;
    logic        rd_raw_b = 1'b0;
    logic [63:0] rd_data_b;

    logic        n_wr_en = 1'b0;
    logic [4:0]  n_wr_addr = '0;
    logic [1:0]  n_wr_fmt = '0;
    logic [63:0] n_wr_data = '0;
    logic [4:0]  n_rd_addr = '0;
    logic [1:0]  n_rd_fmt = '0;
    logic [63:0] n_rd_data;
    logic [63:0] n_rd_data_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fpbox_regfile i_fpbox_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_fmt(wr_fmt),
        .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_fmt_a(rd_fmt_a),
        .rd_raw_a(rd_raw_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b),
        .rd_fmt_b(rd_fmt_b), .rd_raw_b(rd_raw_b), .rd_data_b(rd_data_b)
    );

    fpbox_regfile #(.FLEN(32)) i_fpbox_regfile_narrow (
        .clk(clk), .rst(rst), .wr_en(n_wr_en), .wr_addr(n_wr_addr), .wr_fmt(n_wr_fmt),
        .wr_data(n_wr_data), .rd_addr_a(n_rd_addr), .rd_fmt_a(n_rd_fmt),
        .rd_raw_a(1'b0), .rd_data_a(n_rd_data), .rd_addr_b(n_rd_addr),
        .rd_fmt_b(2'b01), .rd_raw_b(1'b0), .rd_data_b(n_rd_data_b)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state: cleared registers read as NaN when not raw (R10, R3)
        rd_addr_a = 5'd5; rd_fmt_a = 2'b10; rd_raw_a = 1'b0;
        rd_addr_b = 5'd6; rd_fmt_b = 2'b00; rd_raw_b = 1'b0;
        #1;
        check("R10 reset half nan", rd_data_a, 64'h7E00);
        check("R10 reset single nan", rd_data_b, 64'h7FC0_0000);
        rd_raw_b = 1'b1;
        #1;
        check("R10 reset raw zero", rd_data_b, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(i); wr_fmt = VECS[i].wfmt; wr_data = VECS[i].wdata;
            rd_addr_a = 5'(i); rd_fmt_a = VECS[i].rfmt; rd_raw_a = VECS[i].raw;
            rd_addr_b = 5'(i); rd_fmt_b = VECS[i].rfmt; rd_raw_b = VECS[i].raw;
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            check($sformatf("vector %0d port A R1..R6", i), rd_data_a, VECS[i].exp);
            check($sformatf("vector %0d port B R11", i), rd_data_b, VECS[i].exp);
        end

        // R11: ports read different registers in different formats at once
        rd_addr_a = 5'd0; rd_fmt_a = 2'b01; rd_raw_a = 1'b0;
        rd_addr_b = 5'd3; rd_fmt_b = 2'b00; rd_raw_b = 1'b0;
        #1;
        check("R11 port A double", rd_data_a, 64'h4009_21FB_5444_2D18);
        check("R11 port B single", rd_data_b, 64'h0000_0000_FFFF_3C00);

        // R8: same-cycle read returns old contents, new value after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd20; wr_fmt = 2'b01; wr_data = 64'h1111;
        @(negedge clk);
        wr_data = 64'h2222;
        rd_addr_a = 5'd20; rd_fmt_a = 2'b01;
        #1;
        check("R8 read before edge", rd_data_a, 64'h1111);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 read after edge", rd_data_a, 64'h2222);

        // R7: 32-bit registers box half values and refuse double
        n_wr_en = 1'b1; n_wr_addr = 5'd2; n_wr_fmt = 2'b10; n_wr_data = 64'h3C00;
        @(negedge clk);
        n_wr_addr = 5'd3; n_wr_fmt = 2'b00; n_wr_data = 64'h1122_3344;
        @(negedge clk);
        n_wr_fmt = 2'b01; n_wr_data = 64'hAAAA_BBBB_CCCC_DDDD;
        @(negedge clk);
        n_wr_en = 1'b0;
        n_rd_addr = 5'd2; n_rd_fmt = 2'b00;
        #1;
        check("R7 half boxed in 32 bits", n_rd_data, 64'h0000_0000_FFFF_3C00);
        n_rd_addr = 5'd3; n_rd_fmt = 2'b00;
        #1;
        check("R7 double write ignored", n_rd_data, 64'h1122_3344);
        check("R7 double read zero", n_rd_data_b, 64'h0);

        // R10: reset clears previously written contents
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_addr_a = 5'd0; rd_fmt_a = 2'b10; rd_raw_a = 1'b0;
        rd_addr_b = 5'd0; rd_fmt_b = 2'b01; rd_raw_b = 1'b0;
        #1;
        check("R10 cleared half nan", rd_data_a, 64'h7E00);
        check("R10 cleared double zero", rd_data_b, 64'h0);
        rd_fmt_a = 2'b00; rd_raw_a = 1'b1;
        #1;
        check("R10 cleared raw single", rd_data_a, 64'h0);

        finish_run();
    end
endmodule